// File: doc/BRIEF.md
# Circular-Buffer Pointer Address Generator

This block produces one memory address per access for a DSP datapath. It keeps four pointer registers, four step registers and four span registers. An access names one pointer and one step register independently. The pointer's current value is issued as the address, and the pointer then moves by the signed step. When the span tied to that pointer is nonzero, the move wraps inside a circular buffer whose length is the span. When the span is zero, the move is plain 14-bit addition.

A parameter picks one of two builds. The data-only build always marks its address as a data-space access. It can mirror the whole address word, which suits FFT reordering. The dual-space build marks each access as either program space or data space, as a per-access input requests, and it has no mirroring. Registers are loaded through a single write port. The issued address and its space flags appear one clock after the access request.

Top module: `dag_unit`

## Requirements
- R1: After synchronous reset, every pointer, step and span register is zero, `addr_valid`, `dm_sel` and `pm_sel` are 0 and `addr_out` is 0.
- R2: An access (`acc_en`=1) presents the selected pointer's value before the update on `addr_out`, with `addr_valid`=1, from the next clock edge onward. In a cycle without an access, `addr_valid`=0 and `addr_out` keeps its last value.
- R3: After an access, the selected pointer becomes pointer + step, with the step read as a signed 14-bit value. With a zero span, the sum wraps modulo 2^14.
- R4: With span L nonzero, the buffer base is the pointer with its low k bits cleared, where 2^k is the smallest power of two that is at least L. A sum at or above base+L has L subtracted. A sum below base has L added.
- R5: A write (`wr_en`=1) loads `wr_data` into the register chosen by `wr_kind` (0 = pointer, 1 = step, 2 = span) and `wr_idx`, effective at the next edge. `wr_kind`=3 changes nothing. If a write to a pointer and an access to that same pointer occur in the same cycle, the written value wins. An access in that cycle still issues the old value.
- R6: In the data-only build (VARIANT=0), `brev_en`=1 during an access issues the pointer with all 14 bits reversed (output bit b = pointer bit 13-b). The stored pointer and its update are not affected.
- R7: In the data-only build, every access gives `dm_sel`=1 and `pm_sel`=0, whatever the value of `acc_space`.
- R8: In the dual-space build (VARIANT=1), an access with `acc_space`=1 gives `pm_sel`=1, `dm_sel`=0, and one with `acc_space`=0 gives `dm_sel`=1, `pm_sel`=0. `brev_en` has no effect.
- R9: An access changes only the selected pointer. The step is chosen by `acc_msel`, independently of `acc_isel`, and the span is always the one paired with the selected pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register load strobe |
| wr_kind | input | 2 | Register class to load: 0 pointer, 1 step, 2 span, 3 none |
| wr_idx | input | 2 | Register number within the class |
| wr_data | input | 14 | Load value |
| acc_en | input | 1 | Access request |
| acc_isel | input | 2 | Pointer used by the access |
| acc_msel | input | 2 | Step register used by the access |
| acc_space | input | 1 | Dual-space build: 1 program space, 0 data space |
| brev_en | input | 1 | Data-only build: mirror the issued address |
| addr_out | output | 14 | Issued address |
| addr_valid | output | 1 | High for the cycle after an access |
| dm_sel | output | 1 | Issued address targets data space |
| pm_sel | output | 1 | Issued address targets program space |

## Verification
The hardest case to reach from the ports is a pointer leaving its buffer at either end. The negative-step case, which needs a step written as a 14-bit two's-complement value, is the harder of the two. A same-cycle collision between a pointer load and an access to that pointer is also hard to hit. Directed sequences place a pointer near the top of a non-power-of-two buffer and near the 14-bit rollover, and then step it both ways. A long run of seeded random operations keeps step magnitudes below the spans and mixes loads of every class with accesses, so wraps and collisions recur many times. Both builds share the stimulus and are compared against a bench model.

// File: rtl/dag_pkg.sv
package dag_pkg;

    localparam int DAG_ADDR_W = 14;
    localparam int DAG_NUM_PTR = 4;

    typedef enum logic [1:0] {
        WR_POINTER = 2'd0,
        WR_STEP    = 2'd1,
        WR_SPAN    = 2'd2,
        WR_NONE    = 2'd3
    } wr_kind_e;

    // All-ones mask covering the smallest power of two >= len (0 for len 0 or 1).
    function automatic logic [31:0] buf_mask(input logic [31:0] len);
        logic [31:0] v;
        v = (len == 32'd0) ? 32'd0 : len - 32'd1;
        v = v | (v >> 1);
        v = v | (v >> 2);
        v = v | (v >> 4);
        v = v | (v >> 8);
        v = v | (v >> 16);
        return v;
    endfunction

endpackage

// File: rtl/dag_regfile.sv
module dag_regfile
    import dag_pkg::*;
#(
    parameter int AW   = DAG_ADDR_W,
    parameter int NPTR = DAG_NUM_PTR,
    localparam int IDXW = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      wr_kind,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [AW-1:0]   wr_data,
    input  logic            upd_en,
    input  logic [IDXW-1:0] upd_idx,
    input  logic [AW-1:0]   upd_val,
    output logic [AW-1:0]   ptr_q  [NPTR],
    output logic [AW-1:0]   step_q [NPTR],
    output logic [AW-1:0]   span_q [NPTR]
);

    for (genvar p = 0; p < NPTR; p++) begin : g_slot
        logic hit_w;
        assign hit_w = wr_en && (wr_idx == IDXW'(p));

        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[p] <= '0;
            end else if (hit_w && wr_kind == WR_POINTER) begin
                ptr_q[p] <= wr_data;
            end else if (upd_en && upd_idx == IDXW'(p)) begin
                ptr_q[p] <= upd_val;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                step_q[p] <= '0;
            end else if (hit_w && wr_kind == WR_STEP) begin
                step_q[p] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                span_q[p] <= '0;
            end else if (hit_w && wr_kind == WR_SPAN) begin
                span_q[p] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/dag_modulo.sv
module dag_modulo
    import dag_pkg::*;
#(
    parameter int AW = DAG_ADDR_W,
    localparam int SW = AW + 3
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] span,
    output logic [AW-1:0] nxt
);

    logic [AW-1:0]        mask;
    logic [AW-1:0]        base;
    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] lo;
    logic signed [SW-1:0] hi;
    logic signed [SW-1:0] len;
    logic signed [SW-1:0] res;

    always_comb begin
        mask = AW'(buf_mask(32'(span)));
        base = cur & ~mask;
        sum  = $signed({3'b000, cur}) + $signed({{3{step[AW-1]}}, step});
        lo   = $signed({3'b000, base});
        len  = $signed({3'b000, span});
        hi   = lo + len;
        if (span == '0) begin
            res = sum;
        end else if (sum >= hi) begin
            res = sum - len;
        end else if (sum < lo) begin
            res = sum + len;
        end else begin
            res = sum;
        end
        nxt = AW'(res);
    end

endmodule

// File: rtl/dag_outstage.sv
module dag_outstage
    import dag_pkg::*;
#(
    parameter int AW      = DAG_ADDR_W,
    parameter int VARIANT = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_en,
    input  logic [AW-1:0] addr_in,
    input  logic          brev_en,
    input  logic          acc_space,
    output logic [AW-1:0] addr_out,
    output logic          addr_valid,
    output logic          dm_sel,
    output logic          pm_sel
);

    logic [AW-1:0] addr_pick;
    logic          pick_pm;

    if (VARIANT == 0) begin : g_data_only
        logic [AW-1:0] mirrored;
        logic          unused_space;
        for (genvar b = 0; b < AW; b++) begin : g_bit
            assign mirrored[b] = addr_in[AW-1-b];
        end
        assign unused_space = acc_space;
        assign addr_pick    = brev_en ? mirrored : addr_in;
        assign pick_pm      = 1'b0;
    end else begin : g_dual_space
        logic unused_brev;
        assign unused_brev = brev_en;
        assign addr_pick   = addr_in;
        assign pick_pm     = acc_space;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_out   <= '0;
            addr_valid <= 1'b0;
            dm_sel     <= 1'b0;
            pm_sel     <= 1'b0;
        end else if (acc_en) begin
            addr_out   <= addr_pick;
            addr_valid <= 1'b1;
            dm_sel     <= ~pick_pm;
            pm_sel     <= pick_pm;
        end else begin
            addr_valid <= 1'b0;
            dm_sel     <= 1'b0;
            pm_sel     <= 1'b0;
        end
    end

endmodule

// File: rtl/dag_unit.sv
module dag_unit
    import dag_pkg::*;
#(
    parameter int AW      = DAG_ADDR_W,
    parameter int NPTR    = DAG_NUM_PTR,
    parameter int VARIANT = 0,
    localparam int IDXW   = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      wr_kind,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [AW-1:0]   wr_data,
    input  logic            acc_en,
    input  logic [IDXW-1:0] acc_isel,
    input  logic [IDXW-1:0] acc_msel,
    input  logic            acc_space,
    input  logic            brev_en,
    output logic [AW-1:0]   addr_out,
    output logic            addr_valid,
    output logic            dm_sel,
    output logic            pm_sel
);

    logic [AW-1:0] ptr_q  [NPTR];
    logic [AW-1:0] step_q [NPTR];
    logic [AW-1:0] span_q [NPTR];
    logic [AW-1:0] cur_ptr;
    logic [AW-1:0] cur_step;
    logic [AW-1:0] cur_span;
    logic [AW-1:0] next_ptr;

    assign cur_ptr  = ptr_q[acc_isel];
    assign cur_step = step_q[acc_msel];
    assign cur_span = span_q[acc_isel];

    dag_regfile #(.AW(AW), .NPTR(NPTR)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_kind (wr_kind),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .upd_en  (acc_en),
        .upd_idx (acc_isel),
        .upd_val (next_ptr),
        .ptr_q   (ptr_q),
        .step_q  (step_q),
        .span_q  (span_q)
    );

    dag_modulo #(.AW(AW)) u_wrap (
        .cur  (cur_ptr),
        .step (cur_step),
        .span (cur_span),
        .nxt  (next_ptr)
    );

    dag_outstage #(.AW(AW), .VARIANT(VARIANT)) u_out (
        .clk        (clk),
        .rst        (rst),
        .acc_en     (acc_en),
        .addr_in    (cur_ptr),
        .brev_en    (brev_en),
        .acc_space  (acc_space),
        .addr_out   (addr_out),
        .addr_valid (addr_valid),
        .dm_sel     (dm_sel),
        .pm_sel     (pm_sel)
    );

endmodule

// File: rtl/dag_unit_chk.sv
module dag_unit_chk #(
    parameter int AW      = 14,
    parameter int VARIANT = 0
) (
    input logic          clk,
    input logic          rst,
    input logic          acc_en,
    input logic          acc_space,
    input logic [AW-1:0] addr_out,
    input logic          addr_valid,
    input logic          dm_sel,
    input logic          pm_sel
);

    // R2: a request yields a valid address on the next cycle
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        acc_en |=> addr_valid);

    // R2: an idle cycle drops valid and holds the address
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !acc_en |=> (!addr_valid && $stable(addr_out)));

    // R7 / R8: exactly one space flag with a valid address, none otherwise
    a_r8_one_space: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> ($countones({dm_sel, pm_sel}) == 1));

    a_r8_flags_quiet: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |-> (!dm_sel && !pm_sel));

    // R7: the data-only build never targets program space
    a_r7_data_only: assert property (@(posedge clk) disable iff (rst)
        (VARIANT == 0 && acc_en) |=> (dm_sel && !pm_sel));

    // R8: the dual-space build follows the requested space
    a_r8_space_follows: assert property (@(posedge clk) disable iff (rst)
        (VARIANT != 0 && acc_en) |=> (pm_sel == $past(acc_space)));

endmodule

bind dag_unit dag_unit_chk #(.AW(AW), .VARIANT(VARIANT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_en     (acc_en),
    .acc_space  (acc_space),
    .addr_out   (addr_out),
    .addr_valid (addr_valid),
    .dm_sel     (dm_sel),
    .pm_sel     (pm_sel)
);

// File: tb/dag_unit_tb.sv
module dag_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 14;
    localparam int MASK = 16383;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_kind = 2'd3;
    logic [1:0]    wr_idx = '0;
    logic [AW-1:0] wr_data = '0;
    logic          acc_en = 1'b0;
    logic [1:0]    acc_isel = '0;
    logic [1:0]    acc_msel = '0;
    logic          acc_space = 1'b0;
    logic          brev_en = 1'b0;

    logic [AW-1:0] a0_addr, a1_addr;
    logic          a0_valid, a1_valid, a0_dm, a1_dm, a0_pm, a1_pm;

    int n_cmp = 0;
    int n_bad = 0;
    int mi [4];
    int mm [4];
    int ml [4];
    int last0 = 0;
    int last1 = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dag_unit #(.VARIANT(0)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
        .wr_data(wr_data), .acc_en(acc_en), .acc_isel(acc_isel), .acc_msel(acc_msel),
        .acc_space(acc_space), .brev_en(brev_en), .addr_out(a0_addr),
        .addr_valid(a0_valid), .dm_sel(a0_dm), .pm_sel(a0_pm)
    );

    dag_unit #(.VARIANT(1)) u_dut_dual (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
        .wr_data(wr_data), .acc_en(acc_en), .acc_isel(acc_isel), .acc_msel(acc_msel),
        .acc_space(acc_space), .brev_en(brev_en), .addr_out(a1_addr),
        .addr_valid(a1_valid), .dm_sel(a1_dm), .pm_sel(a1_pm)
    );

    function automatic int mirror14(input int v);
        int r = 0;
        for (int b = 0; b < AW; b++) begin
            if (((v >> b) & 1) != 0) r = r | (1 << (AW - 1 - b));
        end
        return r;
    endfunction

    function automatic int model_next(input int i, input int m, input int l);
        int sm = (m >= 8192) ? m - 16384 : m;
        int size = 1;
        int base;
        int s = i + sm;
        if (l == 0) return s & MASK;
        while (size < l) size = size * 2;
        base = i - (i % size);
        if (s >= base + l) s = s - l;
        else if (s < base) s = s + l;
        return s & MASK;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input bit we, input int kind, input int widx, input int wdata,
                        input bit ae, input int isel, input int msel, input bit sp,
                        input bit br, input string req);
        int exp0, exp1;
        wr_en     = we;
        wr_kind   = 2'(kind);
        wr_idx    = 2'(widx);
        wr_data   = AW'(wdata);
        acc_en    = ae;
        acc_isel  = 2'(isel);
        acc_msel  = 2'(msel);
        acc_space = sp;
        brev_en   = br;
        @(posedge clk);
        #1;
        if (ae) begin
            exp0 = br ? mirror14(mi[isel]) : mi[isel];
            exp1 = mi[isel];
            check({req, " valid"}, {a0_valid, a1_valid}, 2'b11);
            check({req, " addr data-only build"}, int'(a0_addr), exp0);
            check({req, " addr dual build"}, int'(a1_addr), exp1);
            check({req, " R7 flags data-only"}, {a0_dm, a0_pm}, 2'b10);
            check({req, " R8 flags dual"}, {a1_dm, a1_pm}, sp ? 2'b01 : 2'b10);
            last0 = exp0;
            last1 = exp1;
            mi[isel] = model_next(mi[isel], mm[msel], ml[isel]);
        end else begin
            check({req, " R2 idle"}, {a0_valid, a1_valid, a0_dm, a0_pm, a1_dm, a1_pm}, 0);
            check({req, " R2 hold"}, {18'(a0_addr), 14'(a1_addr)},
                  {18'(last0), 14'(last1)});
        end
        if (we) begin
            case (kind)
                0: mi[widx] = wdata & MASK;
                1: mm[widx] = wdata & MASK;
                2: ml[widx] = wdata & MASK;
                default: ;
            endcase
        end
    endtask

    task automatic idle(input string req);
        step(0, 3, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed;
        for (int k = 0; k < 4; k++) begin
            mi[k] = 0; mm[k] = 0; ml[k] = 0;
        end
        seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state at the ports
        check("R1 reset outputs", {a0_valid, a1_valid, a0_dm, a0_pm, a1_dm, a1_pm}, 0);
        check("R1 reset addr", {18'(a0_addr), 14'(a1_addr)}, 0);
        // R1: every pointer reads zero and stays zero with zero steps
        for (int k = 0; k < 4; k++) step(0, 3, 0, 0, 1, k, k, 0, 0, "R1 pointer zero");
        idle("R2");

        // R2 R3: linear post-modify
        step(1, 0, 1, 5, 0, 0, 0, 0, 0, "R5 load");
        step(1, 1, 2, 3, 0, 0, 0, 0, 0, "R5 load");
        step(0, 3, 0, 0, 1, 1, 2, 0, 0, "R2 R3 first");
        step(0, 3, 0, 0, 1, 1, 2, 1, 0, "R3 second R8");
        step(0, 3, 0, 0, 1, 1, 2, 0, 0, "R3 third");
        // R3: 14-bit rollover with zero span
        step(1, 0, 3, 16382, 0, 0, 0, 0, 0, "R5 load");
        step(0, 3, 0, 0, 1, 3, 2, 0, 0, "R3 before wrap");
        step(0, 3, 0, 0, 1, 3, 2, 0, 0, "R3 after wrap");

        // R4: circular buffer length 10 at 0x20, steps +4 then -4
        step(1, 0, 0, 32, 0, 0, 0, 0, 0, "R5 load");
        step(1, 2, 0, 10, 0, 0, 0, 0, 0, "R5 load");
        step(1, 1, 1, 4, 0, 0, 0, 0, 0, "R5 load");
        step(1, 1, 3, 16380, 0, 0, 0, 0, 0, "R5 load");
        for (int k = 0; k < 4; k++) step(0, 3, 0, 0, 1, 0, 1, 0, 0, "R4 upward wrap");
        for (int k = 0; k < 4; k++) step(0, 3, 0, 0, 1, 0, 3, 1, 0, "R4 downward wrap");
        // R9: pointer 1 untouched by pointer 0 traffic
        step(0, 3, 0, 0, 1, 1, 0, 0, 0, "R9 other pointer");

        // R6: mirroring in data-only build, ignored by dual build, store intact
        step(1, 0, 2, 1, 0, 0, 0, 0, 0, "R5 load");
        step(1, 1, 0, 1, 0, 0, 0, 0, 0, "R5 load");
        step(0, 3, 0, 0, 1, 2, 0, 0, 1, "R6 mirror");
        step(0, 3, 0, 0, 1, 2, 0, 1, 0, "R6 store intact");

        // R5: write wins over same-cycle update; kind 3 ignored
        step(1, 0, 2, 100, 1, 2, 0, 0, 0, "R5 collision");
        step(1, 3, 2, 777, 1, 2, 0, 0, 0, "R5 after collision");
        step(0, 3, 0, 0, 1, 2, 0, 0, 0, "R5 kind3 ignored");
        idle("R2 idle hold");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int kind = int'($urandom % 4);
            int wd;
            if (kind == 1) wd = (int'($urandom % 31) - 15) & MASK;
            else if (kind == 2) wd = ($urandom % 3 == 0) ? 0 : 16 + int'($urandom % 40);
            else wd = int'($urandom % 16384);
            step(bit'($urandom % 2), kind, int'($urandom % 4), wd,
                 bit'($urandom % 4 != 0), int'($urandom % 4), int'($urandom % 4),
                 bit'($urandom % 2), bit'($urandom % 2), "R3 R4 R5 R9 random");
        end
        idle("R2 end");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule